// File: doc/BRIEF.md
# GPIO port with peripheral pin overrides

This block is an eight-pin general-purpose I/O port. Software writes a direction mask, an output latch, a pin-change mask and a small control word. It reads back the direction, the latch and the mask, together with the synchronized pin levels. Every pin passes through an identical override cell. The cell lets an on-chip peripheral replace any of four register-derived controls: pull-up, drive direction, driven value and input-buffer enable. Each control has its own enable/value pair.

The upper four pins carry timer compare outputs. The top pin is shared by two compare channels. The lower four pins carry a serial peripheral interface in either master or slave role. In both roles the interface forces the direction of the pins that must receive, and the latch bit keeps control of their pull-ups. Every pin also feeds a pin-change detector. The detector synchronizes the pad levels, compares them with the previous sample and raises one sticky flag, which software clears by writing a one. The timers and the serial engine are outside the block and appear only as signals.

The pad itself is modelled as three outputs (drive enable, drive value, pull-up request) and one input level.

Top module: `gpio_altfn_port`

## Requirements
- R1: After reset the direction, latch and change mask read 0, the control bits are 0, no pad is driven, no pull-up is on and the change flag is 0.
- R2: A write with `wr_addr` 0 loads the direction (1 = output), address 1 loads the latch, address 2 loads the change mask, and address 3 loads the control bits: bit 0 is the change-group enable, bit 1 is the global pull-up disable, bit 2 is the input gate, and bit 7 is the flag clear (not stored).
- R3: With no override active, pin i drives `latch[i]` when `dir[i]`=1 and is undriven otherwise, and its pull-up is on exactly when `dir[i]`=0, `latch[i]`=1 and the pull-up disable is 0. A pin that is driven never has its pull-up on.
- R4: On pins 6, 5 and 4 an enabled compare channel (`cmp_en` bits 2, 3 and 4 respectively) replaces only the driven value with the matching `cmp_val` bit. Direction and pull-up stay register-controlled.
- R5: On pin 7 compare channel 0 or channel 1 can replace the driven value. When both are enabled, channel 0 wins.
- R6: With SPI enabled in master role, pin 3 (data in) is forced undriven with pull-up `latch[3]` AND NOT pull-up-disable. Pins 2 and 1 drive `spi_mosi_o` and `spi_sck_o` under register direction.
- R7: With SPI enabled in slave role, pins 2, 1 and 0 are forced undriven with pull-up `latch[i]` AND NOT pull-up-disable. Pin 3 drives `spi_miso_o` under register direction.
- R8: Pin 0 never takes a driven-value override. With SPI disabled, pins 3..0 behave as in R3.
- R9: `pin_sync` follows the (possibly gated) pad inputs two clocks later. The SPI inputs `spi_miso_i`, `spi_mosi_i`, `spi_sck_i` and `spi_ss_n_i` mirror `pin_sync` bits 3, 2, 1 and 0.
- R10: With the input gate set, a pin's input reads 0 unless its change-mask bit and the group enable are both 1.
- R11: With the group enable set, a change on a masked synchronized bit sets `chg_flag` one clock after `pin_sync` shows it. Unmasked pins, or a cleared group enable, leave the flag alone.
- R12: Writing 1 to control bit 7 clears `chg_flag` at that clock edge, except that a change detected in the same cycle keeps it set.
- R13: `spi_slave_sel` is 1 only while SPI is enabled in slave role and the synchronized pin 0 is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| dir_q | output | 8 | Direction readback |
| latch_q | output | 8 | Latch readback |
| mask_q | output | 8 | Change-mask readback |
| pin_sync | output | 8 | Synchronized pin levels |
| chg_flag | output | 1 | Sticky pin-change flag |
| cmp_en | input | 5 | Compare channel enables |
| cmp_val | input | 5 | Compare channel values |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI master role |
| spi_mosi_o | input | 1 | Master data out |
| spi_sck_o | input | 1 | Master serial clock out |
| spi_miso_o | input | 1 | Slave data out |
| spi_miso_i | output | 1 | Pin 3 input to SPI |
| spi_mosi_i | output | 1 | Pin 2 input to SPI |
| spi_sck_i | output | 1 | Pin 1 input to SPI |
| spi_ss_n_i | output | 1 | Pin 0 input to SPI |
| spi_slave_sel | output | 1 | Slave selected |
| pad_di | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad drive enables |
| pad_do | output | 8 | Pad drive values |
| pad_pu | output | 8 | Pad pull-up requests |

## Verification
The bench sweeps SPI enable and role against pull-up disable and four direction/latch patterns. It predicts every pad output from the rules. A design that swapped which pins the master and slave roles force would drive the data-in pin in master mode, or leave slave clock pins driven. The bench also goes through all 32 compare enable combinations, which exposes a wrong channel priority on the shared top pin. The change-flag checks sample at the exact clock when the flag must rise. They also write a clear in the same cycle as a detected change, so an off-by-one synchronizer or a clear that beats a new change is reported.

// File: rtl/gpio_altfn_pkg.sv
package gpio_altfn_pkg;

   localparam int PORT_W   = 8;
   localparam int CMP_CH   = 5;
   localparam int ADDR_W   = 2;

   localparam int CTRL_GRP  = 0;
   localparam int CTRL_PUD  = 1;
   localparam int CTRL_GATE = 2;
   localparam int CTRL_CLR  = 7;

   typedef enum logic [ADDR_W-1:0] {
      SEL_DIR   = 2'd0,
      SEL_LATCH = 2'd1,
      SEL_MASK  = 2'd2,
      SEL_CTRL  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic en;
      logic val;
   } ovr_pair_t;

   typedef struct packed {
      ovr_pair_t pu;
      ovr_pair_t dd;
      ovr_pair_t pv;
      ovr_pair_t die;
   } pin_ovr_t;

   typedef enum logic [2:0] {
      ROLE_CMP_DUAL,
      ROLE_CMP,
      ROLE_SPI_DIN,
      ROLE_SPI_DOUT,
      ROLE_SPI_CLK,
      ROLE_SPI_SEL
   } pin_role_e;

   function automatic pin_role_e role_of(input int idx);
      case (idx)
         7:       return ROLE_CMP_DUAL;
         6, 5, 4: return ROLE_CMP;
         3:       return ROLE_SPI_DIN;
         2:       return ROLE_SPI_DOUT;
         1:       return ROLE_SPI_CLK;
         default: return ROLE_SPI_SEL;
      endcase
   endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_altfn_pkg::*;
#(
   parameter int W = PORT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      latch_q,
   output logic [W-1:0]      mask_q,
   output logic              grp_en_q,
   output logic              pud_q,
   output logic              gate_q,
   output logic              clr_pulse
);

   logic unused_ctrl_bits;
   assign unused_ctrl_bits = ^wr_data[CTRL_CLR-1:CTRL_GATE+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q    <= '0;
         latch_q  <= '0;
         mask_q   <= '0;
         grp_en_q <= 1'b0;
         pud_q    <= 1'b0;
         gate_q   <= 1'b0;
      end else if (wr_en) begin
         case (reg_sel_e'(wr_addr))
            SEL_DIR:   dir_q   <= wr_data;
            SEL_LATCH: latch_q <= wr_data;
            SEL_MASK:  mask_q  <= wr_data;
            default: begin
               grp_en_q <= wr_data[CTRL_GRP];
               pud_q    <= wr_data[CTRL_PUD];
               gate_q   <= wr_data[CTRL_GATE];
            end
         endcase
      end
   end

   assign clr_pulse = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL) && wr_data[CTRL_CLR];

endmodule

// File: rtl/gpio_altfn_map.sv
module gpio_altfn_map
   import gpio_altfn_pkg::*;
#(
   parameter int W    = PORT_W,
   parameter int N_CMP = CMP_CH
) (
   input  logic [W-1:0]     latch_q,
   input  logic [W-1:0]     mask_q,
   input  logic             grp_en,
   input  logic             pud,
   input  logic [N_CMP-1:0] cmp_en,
   input  logic [N_CMP-1:0] cmp_val,
   input  logic             spi_en,
   input  logic             spi_master,
   input  logic             spi_mosi_o,
   input  logic             spi_sck_o,
   input  logic             spi_miso_o,
   output pin_ovr_t [W-1:0] ovr
);

   logic master_on;
   logic slave_on;
   assign master_on = spi_en & spi_master;
   assign slave_on  = spi_en & ~spi_master;

   for (genvar i = 0; i < W; i++) begin : g_pin
      localparam pin_role_e ROLE = role_of(i);
      localparam int        CH   = (W - i < N_CMP) ? W - i : N_CMP - 1;
      logic force_in;
      logic pv_en;
      logic pv_val;

      case (ROLE)
         ROLE_CMP_DUAL: begin : g_dual
            assign force_in = 1'b0;
            assign pv_en    = cmp_en[0] | cmp_en[1];
            assign pv_val   = cmp_en[0] ? cmp_val[0] : cmp_val[1];
         end
         ROLE_CMP: begin : g_cmp
            assign force_in = 1'b0;
            assign pv_en    = cmp_en[CH];
            assign pv_val   = cmp_val[CH];
         end
         ROLE_SPI_DIN: begin : g_din
            assign force_in = master_on;
            assign pv_en    = slave_on;
            assign pv_val   = spi_miso_o;
         end
         ROLE_SPI_DOUT: begin : g_dout
            assign force_in = slave_on;
            assign pv_en    = master_on;
            assign pv_val   = spi_mosi_o;
         end
         ROLE_SPI_CLK: begin : g_clk
            assign force_in = slave_on;
            assign pv_en    = master_on;
            assign pv_val   = spi_sck_o;
         end
         default: begin : g_sel
            assign force_in = slave_on;
            assign pv_en    = 1'b0;
            assign pv_val   = 1'b0;
         end
      endcase

      assign ovr[i] = '{pu:  '{en: force_in, val: latch_q[i] & ~pud},
                        dd:  '{en: force_in, val: 1'b0},
                        pv:  '{en: pv_en,    val: pv_val},
                        die: '{en: mask_q[i] & grp_en, val: 1'b1}};
   end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_altfn_pkg::*;
(
   input  logic     dir,
   input  logic     latch,
   input  logic     pud,
   input  logic     gate,
   input  pin_ovr_t ovr,
   input  logic     pad_di,
   output logic     pad_oe,
   output logic     pad_do,
   output logic     pad_pu,
   output logic     din
);

   logic pu_reg;
   logic die;

   assign pu_reg = ~dir & latch & ~pud;
   assign pad_oe = ovr.dd.en  ? ovr.dd.val  : dir;
   assign pad_do = ovr.pv.en  ? ovr.pv.val  : latch;
   assign pad_pu = ovr.pu.en  ? ovr.pu.val  : pu_reg;
   assign die    = ovr.die.en ? ovr.die.val : ~gate;
   assign din    = pad_di & die;

endmodule

// File: rtl/gpio_pin_change.sv
module gpio_pin_change #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  logic [W-1:0] mask_q,
   input  logic         grp_en,
   input  logic         clr_pulse,
   output logic [W-1:0] sync_q,
   output logic         chg_hit,
   output logic         chg_flag
);

   logic [W-1:0] stage_q [STAGES];
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
         prev_q   <= '0;
         chg_flag <= 1'b0;
      end else begin
         stage_q[0] <= din;
         for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
         prev_q <= stage_q[STAGES-1];
         if (chg_hit)        chg_flag <= 1'b1;
         else if (clr_pulse) chg_flag <= 1'b0;
      end
   end

   assign sync_q  = stage_q[STAGES-1];
   assign chg_hit = grp_en & |(mask_q & (sync_q ^ prev_q));

endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
   import gpio_altfn_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int W           = PORT_W,
   parameter int N_CMP       = CMP_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      latch_q,
   output logic [W-1:0]      mask_q,
   output logic [W-1:0]      pin_sync,
   output logic              chg_flag,
   input  logic [N_CMP-1:0]  cmp_en,
   input  logic [N_CMP-1:0]  cmp_val,
   input  logic              spi_en,
   input  logic              spi_master,
   input  logic              spi_mosi_o,
   input  logic              spi_sck_o,
   input  logic              spi_miso_o,
   output logic              spi_miso_i,
   output logic              spi_mosi_i,
   output logic              spi_sck_i,
   output logic              spi_ss_n_i,
   output logic              spi_slave_sel,
   input  logic [W-1:0]      pad_di,
   output logic [W-1:0]      pad_oe,
   output logic [W-1:0]      pad_do,
   output logic [W-1:0]      pad_pu
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_altfn_port: SYNC_STAGES must be at least 2");
   end
   if (W != PORT_W) begin : g_bad_width
      $error("gpio_altfn_port: pin roles are fixed for an 8-pin port");
   end
   if (N_CMP != CMP_CH) begin : g_bad_cmp
      $error("gpio_altfn_port: five compare channels are required");
   end

   logic             grp_en_q;
   logic             pud_q;
   logic             gate_q;
   logic             clr_pulse;
   logic             chg_hit;
   logic [W-1:0]     din;
   pin_ovr_t [W-1:0] ovr;

   gpio_port_regs #(.W(W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .dir_q     (dir_q),
      .latch_q   (latch_q),
      .mask_q    (mask_q),
      .grp_en_q  (grp_en_q),
      .pud_q     (pud_q),
      .gate_q    (gate_q),
      .clr_pulse (clr_pulse)
   );

   gpio_altfn_map #(.W(W), .N_CMP(N_CMP)) i_map (
      .latch_q    (latch_q),
      .mask_q     (mask_q),
      .grp_en     (grp_en_q),
      .pud        (pud_q),
      .cmp_en     (cmp_en),
      .cmp_val    (cmp_val),
      .spi_en     (spi_en),
      .spi_master (spi_master),
      .spi_mosi_o (spi_mosi_o),
      .spi_sck_o  (spi_sck_o),
      .spi_miso_o (spi_miso_o),
      .ovr        (ovr)
   );

   for (genvar i = 0; i < W; i++) begin : g_cell
      gpio_pin_cell i_cell (
         .dir    (dir_q[i]),
         .latch  (latch_q[i]),
         .pud    (pud_q),
         .gate   (gate_q),
         .ovr    (ovr[i]),
         .pad_di (pad_di[i]),
         .pad_oe (pad_oe[i]),
         .pad_do (pad_do[i]),
         .pad_pu (pad_pu[i]),
         .din    (din[i])
      );
   end

   gpio_pin_change #(.W(W), .STAGES(SYNC_STAGES)) i_pchg (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (din),
      .mask_q    (mask_q),
      .grp_en    (grp_en_q),
      .clr_pulse (clr_pulse),
      .sync_q    (pin_sync),
      .chg_hit   (chg_hit),
      .chg_flag  (chg_flag)
   );

   assign spi_miso_i    = pin_sync[3];
   assign spi_mosi_i    = pin_sync[2];
   assign spi_sck_i     = pin_sync[1];
   assign spi_ss_n_i    = pin_sync[0];
   assign spi_slave_sel = spi_en & ~spi_master & ~pin_sync[0];

endmodule

// File: rtl/gpio_altfn_chk.sv
module gpio_altfn_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       spi_en,
   input logic       spi_master,
   input logic [4:0] cmp_en,
   input logic [7:0] dir_q,
   input logic [7:0] latch_q,
   input logic [7:0] pad_oe,
   input logic [7:0] pad_do,
   input logic [7:0] pad_pu,
   input logic       pud_q,
   input logic       clr_pulse,
   input logic       chg_hit,
   input logic       chg_flag
);

   assert_driven_no_pullup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_pu) == 8'h00);

   assert_pud_blocks_pullup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pud_q |-> pad_pu == 8'h00);

   assert_master_din_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_en && spi_master) |-> !pad_oe[3]);

   assert_slave_pins_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_en && !spi_master) |-> pad_oe[2:0] == 3'b000);

   assert_sel_pin_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pad_do[0] == latch_q[0]);

   assert_idle_follows_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_en && cmp_en == 5'b0) |-> (pad_oe == dir_q && pad_do == latch_q));

   assert_flag_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
      chg_hit |=> chg_flag);

   assert_flag_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse && !chg_hit) |=> !chg_flag);

endmodule

bind gpio_altfn_port gpio_altfn_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .spi_en     (spi_en),
   .spi_master (spi_master),
   .cmp_en     (cmp_en),
   .dir_q      (dir_q),
   .latch_q    (latch_q),
   .pad_oe     (pad_oe),
   .pad_do     (pad_do),
   .pad_pu     (pad_pu),
   .pud_q      (pud_q),
   .clr_pulse  (clr_pulse),
   .chg_hit    (chg_hit),
   .chg_flag   (chg_flag)
);

// File: tb/test_gpio_altfn_port.sv
module test_gpio_altfn_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] dir_q, latch_q, mask_q, pin_sync;
   logic       chg_flag;
   logic [4:0] cmp_en = '0;
   logic [4:0] cmp_val = '0;
   logic       spi_en = 1'b0, spi_master = 1'b0;
   logic       spi_mosi_o = 1'b0, spi_sck_o = 1'b0, spi_miso_o = 1'b0;
   logic       spi_miso_i, spi_mosi_i, spi_sck_i, spi_ss_n_i, spi_slave_sel;
   logic [7:0] pad_di = '0;
   logic [7:0] pad_oe, pad_do, pad_pu;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   gpio_altfn_port i_gpio_altfn_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dir_q(dir_q), .latch_q(latch_q), .mask_q(mask_q), .pin_sync(pin_sync),
      .chg_flag(chg_flag), .cmp_en(cmp_en), .cmp_val(cmp_val),
      .spi_en(spi_en), .spi_master(spi_master), .spi_mosi_o(spi_mosi_o),
      .spi_sck_o(spi_sck_o), .spi_miso_o(spi_miso_o), .spi_miso_i(spi_miso_i),
      .spi_mosi_i(spi_mosi_i), .spi_sck_i(spi_sck_i), .spi_ss_n_i(spi_ss_n_i),
      .spi_slave_sel(spi_slave_sel), .pad_di(pad_di), .pad_oe(pad_oe),
      .pad_do(pad_do), .pad_pu(pad_pu)
   );

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cycles(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] dpat [4];
      logic [7:0] lpat [4];
      dpat[0] = 8'h00; lpat[0] = 8'hFF;
      dpat[1] = 8'hFF; lpat[1] = 8'h00;
      dpat[2] = 8'hA5; lpat[2] = 8'h3C;
      dpat[3] = 8'h5A; lpat[3] = 8'hC3;

      // R1: reset state
      cycles(3);
      check8("R1 dir", dir_q, 8'h00);
      check8("R1 latch", latch_q, 8'h00);
      check8("R1 mask", mask_q, 8'h00);
      check8("R1 oe", pad_oe, 8'h00);
      check8("R1 pu", pad_pu, 8'h00);
      check8("R1 flag", {7'b0, chg_flag}, 8'h00);
      rst_n = 1'b1;
      cycles(2);

      // R2: register writes
      wr(2'd0, 8'hA5);
      wr(2'd1, 8'h3C);
      wr(2'd2, 8'h0F);
      check8("R2 dir", dir_q, 8'hA5);
      check8("R2 latch", latch_q, 8'h3C);
      check8("R2 mask", mask_q, 8'h0F);
      wr(2'd2, 8'h00);

      // R3 R6 R7 R8: SPI role x pull-up disable x direction/latch sweep
      for (int se = 0; se < 2; se++)
         for (int ms = 0; ms < 2; ms++)
            for (int pd = 0; pd < 2; pd++)
               for (int p = 0; p < 4; p++) begin
                  logic [7:0] eo, ed, ep;
                  string tag;
                  wr(2'd0, dpat[p]);
                  wr(2'd1, lpat[p]);
                  wr(2'd3, {6'b0, pd[0], 1'b0});
                  spi_en = se[0]; spi_master = ms[0];
                  spi_mosi_o = p[0]; spi_sck_o = ~p[0]; spi_miso_o = p[1];
                  #1;
                  for (int i = 0; i < 8; i++) begin
                     logic fin;
                     fin = (i == 3 && se == 1 && ms == 1) || (i <= 2 && se == 1 && ms == 0);
                     eo[i] = dpat[p][i] & ~fin;
                     ep[i] = fin ? (lpat[p][i] & ~pd[0]) : (~dpat[p][i] & lpat[p][i] & ~pd[0]);
                     ed[i] = lpat[p][i];
                     if (se == 1 && ms == 0 && i == 3) ed[i] = p[1];
                     if (se == 1 && ms == 1 && i == 2) ed[i] = p[0];
                     if (se == 1 && ms == 1 && i == 1) ed[i] = ~p[0];
                  end
                  tag = (se == 0) ? "R3/R8" : (ms == 1) ? "R6" : "R7";
                  check8({tag, " oe"}, pad_oe, eo);
                  check8({tag, " do"}, pad_do, ed);
                  check8({tag, " pu"}, pad_pu, ep);
               end
      spi_en = 1'b0; spi_master = 1'b0;
      wr(2'd3, 8'h00);

      // R4 R5: compare overrides
      wr(2'd0, 8'hF0);
      wr(2'd1, 8'h50);
      for (int e = 0; e < 32; e++)
         for (int v = 0; v < 2; v++) begin
            logic [7:0] ed;
            cmp_en = e[4:0];
            cmp_val = v[0] ? 5'b10101 : 5'b01010;
            #1;
            ed = 8'h50;
            if (cmp_en[0])      ed[7] = cmp_val[0];
            else if (cmp_en[1]) ed[7] = cmp_val[1];
            if (cmp_en[2]) ed[6] = cmp_val[2];
            if (cmp_en[3]) ed[5] = cmp_val[3];
            if (cmp_en[4]) ed[4] = cmp_val[4];
            check8("R4/R5 do", pad_do, ed);
            check8("R4 oe", pad_oe, 8'hF0);
            check8("R4 pu", pad_pu, 8'h00);
            @(negedge clk);
         end
      cmp_en = '0;

      // R9: input synchronizer latency and SPI input mirrors
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
      cycles(3);
      @(negedge clk) pad_di = 8'h96;
      @(negedge clk);
      check8("R9 one edge", pin_sync, 8'h00);
      @(negedge clk);
      check8("R9 two edges", pin_sync, 8'h96);
      check8("R9 spi in", {4'b0, spi_miso_i, spi_mosi_i, spi_sck_i, spi_ss_n_i}, 8'h06);

      // R13: slave select
      spi_en = 1'b1; spi_master = 1'b0;
      @(negedge clk) pad_di[0] = 1'b0;
      cycles(2);
      check8("R13 selected", {7'b0, spi_slave_sel}, 8'h01);
      @(negedge clk) pad_di[0] = 1'b1;
      cycles(2);
      check8("R13 ss high", {7'b0, spi_slave_sel}, 8'h00);
      @(negedge clk) pad_di[0] = 1'b0;
      spi_master = 1'b1;
      cycles(2);
      check8("R13 master", {7'b0, spi_slave_sel}, 8'h00);
      spi_en = 1'b0; spi_master = 1'b0;

      // R10: input gate
      @(negedge clk) pad_di = 8'hFF;
      wr(2'd3, 8'h04);
      cycles(3);
      check8("R10 gated", pin_sync, 8'h00);
      wr(2'd2, 8'h0F);
      wr(2'd3, 8'h05);
      cycles(3);
      check8("R10 masked pass", pin_sync, 8'h0F);

      // R11 R12: pin-change flag
      wr(2'd3, 8'h01);
      wr(2'd2, 8'h10);
      cycles(3);
      wr(2'd3, 8'h81);
      check8("R12 clear", {7'b0, chg_flag}, 8'h00);
      @(negedge clk) pad_di[5] = 1'b0;
      cycles(4);
      check8("R11 unmasked", {7'b0, chg_flag}, 8'h00);
      @(negedge clk) pad_di[4] = 1'b0;
      cycles(2);
      check8("R11 sync seen", pin_sync, 8'hCF);
      check8("R11 not yet", {7'b0, chg_flag}, 8'h00);
      cycles(1);
      check8("R11 set", {7'b0, chg_flag}, 8'h01);
      wr(2'd3, 8'h81);
      check8("R12 clear again", {7'b0, chg_flag}, 8'h00);
      // clear in the same cycle as a detected change
      @(negedge clk) pad_di[4] = 1'b1;
      cycles(1);
      wr(2'd3, 8'h81);
      check8("R12 set wins", {7'b0, chg_flag}, 8'h01);
      wr(2'd3, 8'h81);
      wr(2'd3, 8'h00);
      @(negedge clk) pad_di[4] = 1'b0;
      cycles(4);
      check8("R11 group off", {7'b0, chg_flag}, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule